// File: doc/BRIEF.md
# Write-Through Data Cache with Read-Priority Store Queue

This block is a direct-mapped data cache that sits between a processor load/store port and a slower memory. Each byte address is split into a tag, a line index and an offset within the block. Each line keeps a valid flag, a tag and one full block of data. A load that finds its block in the cache returns the word on the next cycle. A load that misses reads the whole block from memory, installs it in the indexed line and then returns the requested word.

Stores never wait for memory. Every store is placed in a small first-in first-out store queue that drains one word at a time to memory. A store also updates the cached copy when its block is resident. Stores never allocate a line.

A load miss is serviced before the queued stores reach memory. The exception is a queued store to the same block as the missing load. In that case the queue drains first, until no entry for that block remains, and only then is the block fetched. This way a load can never see memory contents that a queued store is about to change.

Top module: `wtc_dcache`

## Requirements
- R1: After reset every line is invalid, so the first load to any line misses. After reset `cpu_req_ready` is 1, and `cpu_rsp_valid`, `mem_rd_valid` and `mem_wr_valid` are 0.
- R2: Address fields:
  - The tag is the top ADDR_W-IDX_W-OFF_W address bits.
  - The line index is bits [OFF_W+IDX_W-1:OFF_W], which is the block address modulo the number of lines.
  - The word within the block is bits [OFF_W-1:2].
  - Address bits [1:0] do not affect which word a load returns.
- R3: A load that hits returns the addressed word with `cpu_rsp_valid` high exactly one cycle after the request is accepted.
- R4: A load that misses does the following, then a further load to the same block hits:
  - It presents the block address (byte address shifted right by OFF_W) on `mem_rd_addr`.
  - It installs the returned block, where word j occupies bits [32j+31:32j].
  - It responds one cycle after `mem_rd_resp_valid`, two or more cycles after acceptance.
- R5: Blocks that share a line index displace each other. The block that was displaced misses on its next load.
- R6: Each accepted store produces exactly one memory word write carrying its address, data and byte enables, in acceptance order. Once the queue is empty, memory equals the result of applying all stores in program order.
- R7: A store to a resident block changes only the bytes whose `cpu_req_be` bit is set, and a later hit returns the merged word. A store to a non-resident block leaves the cache unchanged: the line keeps its old block, and the stored block still misses afterwards.
- R8: The store queue holds up to WB_DEPTH (4) stores. While it is full, a store request sees `cpu_req_ready` low until an entry has drained.
- R9: When a load misses and a queued store targets the same block, the memory read is issued only after no queued store to that block remains. The load then returns the stored value.
- R10: When a load misses and no queued store targets its block, the memory read is issued before the pending stores. No memory write is presented while the fetch is in progress.
- R11: While a load miss is outstanding, `cpu_req_ready` stays low, so only one request is ever in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cpu_req_valid | input | 1 | Processor request present |
| cpu_req_ready | output | 1 | Request accepted this cycle when valid is also high |
| cpu_req_write | input | 1 | 1 for a store, 0 for a load |
| cpu_req_addr | input | ADDR_W | Byte address |
| cpu_req_wdata | input | WORD_W | Store data |
| cpu_req_be | input | WORD_W/8 | Store byte enables |
| cpu_rsp_valid | output | 1 | Load data valid (one-cycle pulse) |
| cpu_rsp_rdata | output | WORD_W | Load data |
| mem_rd_valid | output | 1 | Block read request |
| mem_rd_ready | input | 1 | Memory accepts the block read |
| mem_rd_addr | output | ADDR_W-OFF_W | Block address to read |
| mem_rd_resp_valid | input | 1 | Block data returned (one pulse per read) |
| mem_rd_data | input | 8*2^OFF_W | Returned block |
| mem_wr_valid | output | 1 | Word write request |
| mem_wr_ready | input | 1 | Memory accepts the word write |
| mem_wr_addr | output | ADDR_W | Byte address of the store |
| mem_wr_data | output | WORD_W | Store data |
| mem_wr_be | output | WORD_W/8 | Store byte enables |

## Verification
The assertions rely on the following input behaviour:
- Memory returns exactly one `mem_rd_resp_valid` pulse for each accepted block read.
- Memory never returns data without a request.
- The processor holds its request stable until it is accepted.

The bench's memory model meets these conditions. It accepts a block read only when idle and answers it after a fixed delay. It never raises a response on its own. The bench drives each request until it is accepted and then drops it. The write port of the memory model is stalled on purpose to fill the queue and to force the read-priority and hazard orderings. The stall is always lifted within a bounded number of cycles.

// File: rtl/wtc_pkg.sv
package wtc_pkg;
  typedef enum logic [1:0] {
    CS_IDLE  = 2'd0,
    CS_DRAIN = 2'd1,
    CS_FETCH = 2'd2,
    CS_WAIT  = 2'd3
  } ctl_state_e;
endpackage

// File: rtl/wtc_store_queue.sv
// Circular store queue; DEPTH must be a power of two, at least 2.
module wtc_store_queue #(
  parameter int ADDR_W = 34,
  parameter int WORD_W = 32,
  parameter int OFF_W  = 5,
  parameter int DEPTH  = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    push,
  input  logic [ADDR_W-1:0]       push_addr,
  input  logic [WORD_W-1:0]       push_data,
  input  logic [WORD_W/8-1:0]     push_be,
  output logic                    full,
  input  logic                    drain_en,
  output logic                    out_valid,
  input  logic                    out_ready,
  output logic [ADDR_W-1:0]       out_addr,
  output logic [WORD_W-1:0]       out_data,
  output logic [WORD_W/8-1:0]     out_be,
  input  logic [ADDR_W-OFF_W-1:0] probe_blk,
  output logic                    probe_hit
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int BE_W  = WORD_W / 8;

  logic [ADDR_W-1:0] addr_q [DEPTH];
  logic [WORD_W-1:0] data_q [DEPTH];
  logic [BE_W-1:0]   be_q   [DEPTH];
  logic [DEPTH-1:0]  vld_q, vld_d;
  logic [PTR_W-1:0]  head_q, head_d, tail_q, tail_d;
  logic [DEPTH-1:0]  match_vec;
  logic              empty, pop;

  assign full      = vld_q[tail_q];
  assign empty     = ~vld_q[head_q];
  assign out_valid = drain_en & ~empty;
  assign pop       = out_valid & out_ready;
  assign out_addr  = addr_q[head_q];
  assign out_data  = data_q[head_q];
  assign out_be    = be_q[head_q];

  for (genvar i = 0; i < DEPTH; i++) begin : g_probe
    assign match_vec[i] = vld_q[i] && (addr_q[i][ADDR_W-1:OFF_W] == probe_blk);
  end
  assign probe_hit = |match_vec;

  always_comb begin
    vld_d  = vld_q;
    head_d = head_q;
    tail_d = tail_q;
    if (pop) begin
      vld_d[head_q] = 1'b0;
      head_d        = head_q + PTR_W'(1);
    end
    if (push) begin
      vld_d[tail_q] = 1'b1;
      tail_d        = tail_q + PTR_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= '0;
      head_q <= '0;
      tail_q <= '0;
    end else begin
      vld_q  <= vld_d;
      head_q <= head_d;
      tail_q <= tail_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push) begin
      addr_q[tail_q] <= push_addr;
      data_q[tail_q] <= push_data;
      be_q[tail_q]   <= push_be;
    end
  end

  // R8: the controller must never push into a full queue
  a_r8_no_push_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);
endmodule

// File: rtl/wtc_line_store.sv
module wtc_line_store #(
  parameter int IDX_W  = 8,
  parameter int TAG_W  = 21,
  parameter int LINE_W = 256,
  parameter int WORD_W = 32
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic [IDX_W-1:0]                  look_idx,
  input  logic [TAG_W-1:0]                  look_tag,
  input  logic [$clog2(LINE_W/WORD_W)-1:0]  look_wsel,
  output logic                              look_hit,
  output logic [WORD_W-1:0]                 look_word,
  input  logic                              fill_en,
  input  logic [IDX_W-1:0]                  fill_idx,
  input  logic [TAG_W-1:0]                  fill_tag,
  input  logic [LINE_W-1:0]                 fill_line,
  input  logic                              upd_en,
  input  logic [IDX_W-1:0]                  upd_idx,
  input  logic [$clog2(LINE_W/WORD_W)-1:0]  upd_wsel,
  input  logic [WORD_W-1:0]                 upd_data,
  input  logic [WORD_W/8-1:0]               upd_be
);
  localparam int LINES = 1 << IDX_W;
  localparam int BE_W  = WORD_W / 8;

  logic [LINES-1:0]  vld_q, vld_d;
  logic [TAG_W-1:0]  tag_q [LINES];
  logic [LINE_W-1:0] dat_q [LINES];
  logic [LINE_W-1:0] merged;

  assign look_hit  = vld_q[look_idx] && (tag_q[look_idx] == look_tag);
  assign look_word = dat_q[look_idx][look_wsel*WORD_W +: WORD_W];

  always_comb begin
    merged = dat_q[upd_idx];
    for (int b = 0; b < BE_W; b++) begin
      if (upd_be[b]) merged[upd_wsel*WORD_W + b*8 +: 8] = upd_data[b*8 +: 8];
    end
  end

  always_comb begin
    vld_d = vld_q;
    if (fill_en) vld_d[fill_idx] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= '0;
    else        vld_q <= vld_d;
  end

  always_ff @(posedge clk) begin
    if (fill_en) begin
      tag_q[fill_idx] <= fill_tag;
      dat_q[fill_idx] <= fill_line;
    end else if (upd_en) begin
      dat_q[upd_idx] <= merged;
    end
  end

  // R4: an installed block is valid and tagged on the following cycle
  a_r4_fill_installs_line: assert property (@(posedge clk) disable iff (!rst_n)
    fill_en |=> (vld_q[$past(fill_idx)] && (tag_q[$past(fill_idx)] == $past(fill_tag))));
endmodule

// File: rtl/wtc_dcache.sv
module wtc_dcache
  import wtc_pkg::*;
#(
  parameter int ADDR_W   = 34,
  parameter int IDX_W    = 8,
  parameter int OFF_W    = 5,
  parameter int WORD_W   = 32,
  parameter int WB_DEPTH = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cpu_req_valid,
  output logic                       cpu_req_ready,
  input  logic                       cpu_req_write,
  input  logic [ADDR_W-1:0]          cpu_req_addr,
  input  logic [WORD_W-1:0]          cpu_req_wdata,
  input  logic [WORD_W/8-1:0]        cpu_req_be,
  output logic                       cpu_rsp_valid,
  output logic [WORD_W-1:0]          cpu_rsp_rdata,
  output logic                       mem_rd_valid,
  input  logic                       mem_rd_ready,
  output logic [ADDR_W-OFF_W-1:0]    mem_rd_addr,
  input  logic                       mem_rd_resp_valid,
  input  logic [8*(2**OFF_W)-1:0]    mem_rd_data,
  output logic                       mem_wr_valid,
  input  logic                       mem_wr_ready,
  output logic [ADDR_W-1:0]          mem_wr_addr,
  output logic [WORD_W-1:0]          mem_wr_data,
  output logic [WORD_W/8-1:0]        mem_wr_be
);
  localparam int TAG_W  = ADDR_W - IDX_W - OFF_W;
  localparam int BLK_W  = ADDR_W - OFF_W;
  localparam int LINE_W = 8 * (2**OFF_W);
  localparam int BE_W   = WORD_W / 8;
  localparam int BYTE_W = $clog2(BE_W);
  localparam int WSEL_W = OFF_W - BYTE_W;

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rs_q;
  logic       rst_i_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_i_n = rs_q[1];

  // address fields
  logic [TAG_W-1:0]  req_tag;
  logic [IDX_W-1:0]  req_idx;
  logic [WSEL_W-1:0] req_wsel;
  logic [BLK_W-1:0]  req_blk;
  assign req_tag  = cpu_req_addr[ADDR_W-1 -: TAG_W];
  assign req_idx  = cpu_req_addr[OFF_W +: IDX_W];
  assign req_wsel = cpu_req_addr[BYTE_W +: WSEL_W];
  assign req_blk  = cpu_req_addr[ADDR_W-1:OFF_W];

  ctl_state_e        state_q, state_d;
  logic [BLK_W-1:0]  miss_blk_q;
  logic [WSEL_W-1:0] miss_wsel_q;
  logic              miss_ld;
  logic              rsp_valid_q, rsp_valid_d, rsp_ld;
  logic [WORD_W-1:0] rsp_data_q, rsp_data_d;
  logic              accept, look_hit, fill_en, upd_en, push;
  logic              wb_full, probe_hit, drain_en;
  logic [WORD_W-1:0] look_word, fetched_word;
  logic [BLK_W-1:0]  probe_blk;

  assign cpu_req_ready = (state_q == CS_IDLE) && (!cpu_req_write || !wb_full);
  assign accept        = cpu_req_valid && cpu_req_ready;
  assign push          = accept && cpu_req_write;
  assign upd_en        = push && look_hit;
  assign drain_en      = (state_q == CS_IDLE) || (state_q == CS_DRAIN);
  assign probe_blk     = (state_q == CS_IDLE) ? req_blk : miss_blk_q;
  assign mem_rd_valid  = (state_q == CS_FETCH);
  assign mem_rd_addr   = miss_blk_q;
  assign fetched_word  = mem_rd_data[miss_wsel_q*WORD_W +: WORD_W];
  assign cpu_rsp_valid = rsp_valid_q;
  assign cpu_rsp_rdata = rsp_data_q;

  always_comb begin
    state_d     = state_q;
    miss_ld     = 1'b0;
    fill_en     = 1'b0;
    rsp_valid_d = 1'b0;
    rsp_ld      = 1'b0;
    rsp_data_d  = look_word;
    case (state_q)
      CS_IDLE: begin
        if (accept && !cpu_req_write) begin
          if (look_hit) begin
            rsp_valid_d = 1'b1;
            rsp_ld      = 1'b1;
          end else begin
            miss_ld = 1'b1;
            state_d = probe_hit ? CS_DRAIN : CS_FETCH;
          end
        end
      end
      CS_DRAIN: if (!probe_hit) state_d = CS_FETCH;
      CS_FETCH: if (mem_rd_ready) state_d = CS_WAIT;
      CS_WAIT: begin
        if (mem_rd_resp_valid) begin
          fill_en     = 1'b1;
          rsp_valid_d = 1'b1;
          rsp_ld      = 1'b1;
          rsp_data_d  = fetched_word;
          state_d     = CS_IDLE;
        end
      end
      default: state_d = CS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      state_q     <= CS_IDLE;
      rsp_valid_q <= 1'b0;
    end else begin
      state_q     <= state_d;
      rsp_valid_q <= rsp_valid_d;
    end
  end

  always_ff @(posedge clk) begin
    if (miss_ld) begin
      miss_blk_q  <= req_blk;
      miss_wsel_q <= req_wsel;
    end
    if (rsp_ld) rsp_data_q <= rsp_data_d;
  end

  wtc_line_store #(
    .IDX_W(IDX_W), .TAG_W(TAG_W), .LINE_W(LINE_W), .WORD_W(WORD_W)
  ) u_lines (
    .clk(clk), .rst_n(rst_i_n),
    .look_idx(req_idx), .look_tag(req_tag), .look_wsel(req_wsel),
    .look_hit(look_hit), .look_word(look_word),
    .fill_en(fill_en), .fill_idx(miss_blk_q[IDX_W-1:0]),
    .fill_tag(miss_blk_q[BLK_W-1 -: TAG_W]), .fill_line(mem_rd_data),
    .upd_en(upd_en), .upd_idx(req_idx), .upd_wsel(req_wsel),
    .upd_data(cpu_req_wdata), .upd_be(cpu_req_be)
  );

  wtc_store_queue #(
    .ADDR_W(ADDR_W), .WORD_W(WORD_W), .OFF_W(OFF_W), .DEPTH(WB_DEPTH)
  ) u_queue (
    .clk(clk), .rst_n(rst_i_n),
    .push(push), .push_addr(cpu_req_addr), .push_data(cpu_req_wdata),
    .push_be(cpu_req_be), .full(wb_full), .drain_en(drain_en),
    .out_valid(mem_wr_valid), .out_ready(mem_wr_ready),
    .out_addr(mem_wr_addr), .out_data(mem_wr_data), .out_be(mem_wr_be),
    .probe_blk(probe_blk), .probe_hit(probe_hit)
  );

  // R9: a block read is never presented while a queued store hits that block
  a_r9_match_drained_first: assert property (@(posedge clk) disable iff (!rst_i_n)
    mem_rd_valid |-> !probe_hit);
  // R10: stores are held back for the whole fetch
  a_r10_no_write_during_fetch: assert property (@(posedge clk) disable iff (!rst_i_n)
    ((state_q == CS_FETCH) || (state_q == CS_WAIT)) |-> !mem_wr_valid);
  // R3: accepted load hit answers on the next cycle
  a_r3_hit_next_cycle: assert property (@(posedge clk) disable iff (!rst_i_n)
    (accept && !cpu_req_write && look_hit) |=> cpu_rsp_valid);
  // R4: block arrival during a fetch answers on the next cycle
  a_r4_rsp_after_fill: assert property (@(posedge clk) disable iff (!rst_i_n)
    ((state_q == CS_WAIT) && mem_rd_resp_valid) |=> cpu_rsp_valid);
endmodule

// File: tb/sim_wtc_dcache.sv
`timescale 1ns/1ps
module sim_wtc_dcache;
  localparam int LAT = 2;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cpu_req_valid, cpu_req_ready, cpu_req_write;
  logic [33:0] cpu_req_addr;
  logic [31:0] cpu_req_wdata;
  logic [3:0]  cpu_req_be;
  logic        cpu_rsp_valid;
  logic [31:0] cpu_rsp_rdata;
  logic        mem_rd_valid, mem_rd_ready;
  logic [28:0] mem_rd_addr;
  logic        mem_rd_resp_valid;
  logic [255:0] mem_rd_data;
  logic        mem_wr_valid, mem_wr_ready;
  logic [33:0] mem_wr_addr;
  logic [31:0] mem_wr_data;
  logic [3:0]  mem_wr_be;

  always #5 clk = ~clk;

  wtc_dcache #(.IDX_W(2)) u0 (
    .clk(clk), .rst_n(rst_n),
    .cpu_req_valid(cpu_req_valid), .cpu_req_ready(cpu_req_ready),
    .cpu_req_write(cpu_req_write), .cpu_req_addr(cpu_req_addr),
    .cpu_req_wdata(cpu_req_wdata), .cpu_req_be(cpu_req_be),
    .cpu_rsp_valid(cpu_rsp_valid), .cpu_rsp_rdata(cpu_rsp_rdata),
    .mem_rd_valid(mem_rd_valid), .mem_rd_ready(mem_rd_ready),
    .mem_rd_addr(mem_rd_addr), .mem_rd_resp_valid(mem_rd_resp_valid),
    .mem_rd_data(mem_rd_data),
    .mem_wr_valid(mem_wr_valid), .mem_wr_ready(mem_wr_ready),
    .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data), .mem_wr_be(mem_wr_be)
  );

  // memory model: 64 blocks of 8 words
  logic [31:0] mem_words [512];
  logic [31:0] gold [512];
  logic        rd_busy, wr_stall;
  int          rd_cnt, wr_count, snap_wr, store_count;
  logic [28:0] rd_blk;
  int          checks, errors;
  bit          sh_vld [4];
  int          sh_tag [4];

  assign mem_rd_ready = !rd_busy;
  assign mem_wr_ready = !wr_stall;

  always_comb begin
    for (int j = 0; j < 8; j++) mem_rd_data[j*32 +: 32] = mem_words[{rd_blk[5:0], 3'(j)}];
  end

  always @(posedge clk) begin
    mem_rd_resp_valid <= 1'b0;
    if (mem_wr_valid && mem_wr_ready) begin
      for (int b = 0; b < 4; b++)
        if (mem_wr_be[b]) mem_words[mem_wr_addr[10:2]][b*8 +: 8] <= mem_wr_data[b*8 +: 8];
      wr_count <= wr_count + 1;
    end
    if (mem_rd_valid && mem_rd_ready) begin
      rd_busy <= 1'b1;
      rd_cnt  <= LAT;
      rd_blk  <= mem_rd_addr;
      snap_wr <= wr_count;
    end else if (rd_busy) begin
      if (rd_cnt == 1) begin
        mem_rd_resp_valid <= 1'b1;
        rd_busy <= 1'b0;
      end else rd_cnt <= rd_cnt - 1;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cpu_read(input logic [33:0] a, output logic [31:0] d, output int lat, output bit rdy_seen);
    bit acc;
    @(negedge clk);
    cpu_req_valid = 1'b1; cpu_req_write = 1'b0; cpu_req_addr = a; #1;
    acc = cpu_req_ready;
    while (!acc) begin @(negedge clk); #1; acc = cpu_req_ready; end
    @(negedge clk);
    cpu_req_valid = 1'b0; lat = 1; rdy_seen = 1'b0;
    while (!cpu_rsp_valid) begin
      if (cpu_req_ready) rdy_seen = 1'b1;
      @(negedge clk); lat++;
    end
    d = cpu_rsp_rdata;
  endtask

  task automatic wr(input logic [33:0] a, input logic [31:0] dat, input logic [3:0] be);
    bit acc;
    @(negedge clk);
    cpu_req_valid = 1'b1; cpu_req_write = 1'b1; cpu_req_addr = a;
    cpu_req_wdata = dat; cpu_req_be = be; #1;
    acc = cpu_req_ready;
    while (!acc) begin @(negedge clk); #1; acc = cpu_req_ready; end
    @(negedge clk);
    cpu_req_valid = 1'b0;
    for (int b = 0; b < 4; b++) if (be[b]) gold[a[10:2]][b*8 +: 8] = dat[b*8 +: 8];
    store_count++;
  endtask

  task automatic rd_chk(input logic [33:0] a, input string req);
    int blk, idx, lat;
    bit exp_hit, rs;
    logic [31:0] d;
    blk = int'(a >> 5);
    idx = blk % 4;
    exp_hit = sh_vld[idx] && (sh_tag[idx] == blk / 4);
    cpu_read(a, d, lat, rs);
    chk(d == gold[a[10:2]], req, d, gold[a[10:2]]);
    if (exp_hit) chk(lat == 1, "R3 hit latency", lat, 1);
    else begin
      chk(lat >= 3, "R4 miss latency", lat, 3);
      chk(!rs, "R11 ready low during miss", 32'(rs), 0);
      sh_vld[idx] = 1'b1;
      sh_tag[idx] = blk / 4;
    end
  endtask

  task automatic wait_drain();
    @(negedge clk);
    while (mem_wr_valid) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    checks = 0; errors = 0; store_count = 0;
    wr_count = 0; snap_wr = 0; rd_busy = 1'b0; rd_cnt = 0; rd_blk = '0;
    mem_rd_resp_valid = 1'b0; wr_stall = 1'b0;
    cpu_req_valid = 1'b0; cpu_req_write = 1'b0; cpu_req_addr = '0;
    cpu_req_wdata = '0; cpu_req_be = '0;
    for (int w = 0; w < 512; w++) begin
      mem_words[w] = 32'h5A00_0000 ^ (32'(w) * 32'h0001_0003);
      gold[w]      = 32'h5A00_0000 ^ (32'(w) * 32'h0001_0003);
    end
    for (int i = 0; i < 4; i++) begin sh_vld[i] = 1'b0; sh_tag[i] = 0; end
    rst_n = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state
    chk(cpu_req_ready == 1'b1, "R1 ready", 32'(cpu_req_ready), 1);
    chk(cpu_rsp_valid == 1'b0, "R1 rsp_valid", 32'(cpu_rsp_valid), 0);
    chk(mem_rd_valid == 1'b0, "R1 mem_rd_valid", 32'(mem_rd_valid), 0);
    chk(mem_wr_valid == 1'b0, "R1 mem_wr_valid", 32'(mem_wr_valid), 0);

    // R1 R2 R4 R5: forward sweep, byte bits vary and must not matter
    for (int blk = 0; blk < 8; blk++)
      for (int w = 0; w < 8; w++)
        rd_chk(34'(blk*32 + w*4 + (w % 4)), "R2 sweep data");
    // R5: reverse sweep, lower blocks were displaced
    for (int blk = 7; blk >= 0; blk--)
      for (int w = 0; w < 8; w += 3)
        rd_chk(34'(blk*32 + w*4), "R5 conflict data");

    // R7: store hits with every byte-enable pattern
    for (int be = 1; be < 16; be++) begin
      wr(34'(32 + 4*(be % 8)), 32'h1122_3344 * 32'(be), 4'(be));
      rd_chk(34'(32 + 4*(be % 8)), "R7 merged hit");
    end

    // R7: store miss does not allocate (block 20 shares line 0 with block 0)
    wr(34'(20*32 + 8), 32'hCAFE_F00D, 4'hF);
    rd_chk(34'(8), "R7 line kept old block");
    rd_chk(34'(20*32 + 8), "R7 no-allocate miss");

    // R10 then R9: addresses 512 and 1024 share line 0
    wait_drain();
    wr_stall = 1'b1;
    wr(34'd516, 32'hDEAD_BEEF, 4'hF);
    begin
      int w0;
      w0 = wr_count;
      rd_chk(34'd1032, "R10 unrelated miss data");
      chk(snap_wr == w0, "R10 read before writes", 32'(snap_wr), 32'(w0));
      chk(wr_count == w0, "R10 store still queued", 32'(wr_count), 32'(w0));
    end
    fork
      begin repeat (10) @(negedge clk); wr_stall = 1'b0; end
      rd_chk(34'd516, "R9 hazard returns stored value");
    join
    chk(snap_wr == store_count, "R9 drained before read", 32'(snap_wr), 32'(store_count));

    // R8: queue full stalls a fifth store
    wait_drain();
    wr_stall = 1'b1;
    for (int i = 0; i < 4; i++) wr(34'((40+i)*32), 32'h7700_0000 + 32'(i), 4'hF);
    @(negedge clk);
    cpu_req_valid = 1'b1; cpu_req_write = 1'b1; cpu_req_addr = 34'(44*32);
    cpu_req_wdata = 32'h0BAD_CAFE; cpu_req_be = 4'b0101; #1;
    chk(cpu_req_ready == 1'b0, "R8 full stalls store", 32'(cpu_req_ready), 0);
    repeat (3) @(negedge clk); #1;
    chk(cpu_req_ready == 1'b0, "R8 still stalled", 32'(cpu_req_ready), 0);
    wr_stall = 1'b0;
    begin
      bit acc;
      acc = cpu_req_ready;
      while (!acc) begin @(negedge clk); #1; acc = cpu_req_ready; end
      @(negedge clk);
      cpu_req_valid = 1'b0;
      for (int b = 0; b < 4; b++)
        if (cpu_req_be[b]) gold[(44*32) >> 2][b*8 +: 8] = cpu_req_wdata[b*8 +: 8];
      store_count++;
    end
    rd_chk(34'(44*32), "R8 stalled store landed");

    // R6: all stores reached memory in order
    wait_drain();
    chk(wr_count == store_count, "R6 one write per store", 32'(wr_count), 32'(store_count));
    begin
      int mm;
      mm = 0;
      for (int w = 0; w < 512; w++) if (mem_words[w] !== gold[w]) mm++;
      chk(mm == 0, "R6 memory image", 32'(mm), 0);
    end
    finish_run();
  end
endmodule